// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes the raw parallel output of an image sensor (pixel clock, line sync, frame sync and a sample bus) and turns it into a clean pixel stream. The sensor signals are brought into the system clock domain through a short synchronizer. The pixel clock is oversampled, and its chosen edge marks each sample. Each sync signal has its own active-level setting. Column and row counters locate every sample in the frame. A crop window with inclusive bounds can be enabled separately for columns and for rows. Kept pixels leave on a valid/ready stream. The first kept pixel of a frame carries a start-of-frame flag and the last kept pixel of each row carries an end-of-line flag.

Capture is controlled by one-cycle start and stop commands. A start arms the block, and capture begins at the next frame sync. In single-shot mode one frame is taken. In continuous mode frames are taken until a stop is given. A stop never cuts a frame short: the frame in progress is delivered in full, and capture ends at the next frame sync. The sample width setting masks off bus bits above the selected width.

Top module: `cam_capture_fe`

## Requirements
- R1: With `cfg_pclk_fall` = 0 the bus and syncs are sampled at rising edges of `cam_pclk`. With 1 they are sampled at falling edges. The pixel clock runs freely, including during blanking.
- R2: `cam_hsync` is active high when `cfg_hsync_low` = 0 and active low when it is 1. `cam_vsync` is set the same way by `cfg_vsync_low`. The two settings are independent.
- R3: A line is the run of samples with the line sync active, and its first sample is column 0. A frame starts at the first sample where the frame sync becomes active. The first line after a frame start is row 0, and the row number rises by one at the end of each line.
- R4: With `cfg_col_crop_en` = 1, a sample is kept only if `cfg_col_first` <= column <= `cfg_col_last`. If first > last, no sample is kept. With the enable at 0, every column is kept whatever the bounds hold.
- R5: With `cfg_row_crop_en` = 1, a sample is kept only if `cfg_row_first` <= row <= `cfg_row_last`. With the enable at 0, every row is kept.
- R6: `out_sof` is 1 only on the first kept pixel of each captured frame. `out_eol` is 1 only on the last kept pixel of each row.
- R7: `cfg_sample_bits` selects the sample width: 0 = 8, 1 = 9, 2 = 10, 3 = 12 bits. Bits of `out_data` above the width are 0, and bits below it equal the bus.
- R8: `cmd_start` while idle sets `status_active` on the next cycle. Capture begins at the next frame start. Samples before that frame start are not delivered.
- R9: In single-shot mode (`cfg_continuous` = 0) exactly one frame is delivered. `status_active` stays 1 until the next frame start and then falls. That frame is not delivered.
- R10: In continuous mode frames are delivered back to back. After `cmd_stop`, the current frame is still delivered in full. `status_active` falls only at the next frame start, and no later frame is delivered.
- R11: While `out_valid` = 1 and `out_ready` = 0, the output word and its flags hold steady. The sink must accept each word within one pixel period.
- R12: After reset `out_valid` = 0 and `status_active` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock (oversampled) |
| cam_hsync | input | 1 | Sensor line sync |
| cam_vsync | input | 1 | Sensor frame sync |
| cam_data | input | DATA_W | Sensor sample bus |
| cfg_pclk_fall | input | 1 | Sample on falling pixel clock edge |
| cfg_hsync_low | input | 1 | Line sync is active low |
| cfg_vsync_low | input | 1 | Frame sync is active low |
| cfg_sample_bits | input | 2 | Sample width code |
| cfg_col_crop_en | input | 1 | Enable column crop |
| cfg_row_crop_en | input | 1 | Enable row crop |
| cfg_col_first | input | CNT_W | First kept column (inclusive) |
| cfg_col_last | input | CNT_W | Last kept column (inclusive) |
| cfg_row_first | input | CNT_W | First kept row (inclusive) |
| cfg_row_last | input | CNT_W | Last kept row (inclusive) |
| cfg_continuous | input | 1 | Continuous (1) or single-shot (0) |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | DATA_W | Pixel sample |
| out_sof | output | 1 | First kept pixel of frame |
| out_eol | output | 1 | Last kept pixel of row |
| status_active | output | 1 | Capture armed or running |

## Verification
Some properties are checked on every cycle:
- the stream word and its flags hold still under backpressure;
- no data bit above the selected sample width is ever set;
- a start from idle raises the active status at once;
- the active status falls only at a frame start;
- a frame opens only at a detected frame sync.

Other behaviour only the bench scenarios can show. This covers the exact pixel order, which crop bounds are honoured, where the flags fall, edge and level polarity, and single-shot against continuous termination. The bench sweeps every inclusive column and row window of a small frame and compares the delivered stream word by word with an arithmetic model.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2
  } cap_state_e;

  // Low-order ones for the selected sample width code.
  function automatic logic [15:0] width_mask(input logic [1:0] code);
    logic [15:0] m;
    unique case (code)
      2'd0:    m = 16'h00FF;
      2'd1:    m = 16'h01FF;
      2'd2:    m = 16'h03FF;
      default: m = 16'h0FFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cam_in_sync.sv
module cam_in_sync #(
  parameter int DATA_W = 12,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cfg_pclk_fall,
  input  logic              cfg_hs_low,
  input  logic              cfg_vs_low,
  output logic              px_evt,
  output logic              hs_act,
  output logic              vs_act,
  output logic [DATA_W-1:0] px_data
);
  localparam int BUS_W = DATA_W + 3;

  logic [STAGES-1:0][BUS_W-1:0] stage_q;
  logic [BUS_W-1:0]             bus_cur;
  logic                         pclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      pclk_prev_q <= 1'b0;
    end else begin
      stage_q[0] <= {pclk_i, hs_i, vs_i, data_i};
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      pclk_prev_q <= bus_cur[BUS_W-1];
    end
  end

  assign bus_cur = stage_q[STAGES-1];

  always_comb begin
    if (cfg_pclk_fall) px_evt = pclk_prev_q & ~bus_cur[BUS_W-1];
    else               px_evt = ~pclk_prev_q & bus_cur[BUS_W-1];
    hs_act  = bus_cur[BUS_W-2] ^ cfg_hs_low;
    vs_act  = bus_cur[BUS_W-3] ^ cfg_vs_low;
    px_data = bus_cur[DATA_W-1:0];
  end

endmodule

// File: rtl/cam_sync_track.sv
module cam_sync_track #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             px_evt,
  input  logic             hs_act,
  input  logic             vs_act,
  input  logic             cfg_col_en,
  input  logic             cfg_row_en,
  input  logic [CNT_W-1:0] cfg_col_first,
  input  logic [CNT_W-1:0] cfg_col_last,
  input  logic [CNT_W-1:0] cfg_row_first,
  input  logic [CNT_W-1:0] cfg_row_last,
  output logic             fs_evt,
  output logic             win_hit
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             hs_prev_q, hs_prev_d;
  logic             vs_prev_q, vs_prev_d;
  logic [CNT_W-1:0] col_q, col_d, row_q, row_d;
  logic [CNT_W-1:0] col_idx;
  logic             line_end, col_ok, row_ok;

  always_comb begin
    col_idx  = hs_prev_q ? col_q : '0;
    line_end = px_evt & hs_prev_q & ~hs_act;
    fs_evt   = px_evt & vs_act & ~vs_prev_q;

    hs_prev_d = px_evt ? hs_act : hs_prev_q;
    vs_prev_d = px_evt ? vs_act : vs_prev_q;

    col_d = col_q;
    if (px_evt && hs_act) col_d = (col_idx == CNT_TOP) ? CNT_TOP : col_idx + 1'b1;

    row_d = row_q;
    if (fs_evt)        row_d = '0;
    else if (line_end) row_d = (row_q == CNT_TOP) ? CNT_TOP : row_q + 1'b1;

    col_ok  = ~cfg_col_en | ((col_idx >= cfg_col_first) & (col_idx <= cfg_col_last));
    row_ok  = ~cfg_row_en | ((row_q >= cfg_row_first) & (row_q <= cfg_row_last));
    win_hit = hs_act & col_ok & row_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev_q <= 1'b0;
      vs_prev_q <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
    end else begin
      hs_prev_q <= hs_prev_d;
      vs_prev_q <= vs_prev_d;
      col_q     <= col_d;
      row_q     <= row_d;
    end
  end

endmodule

// File: rtl/cam_cap_ctrl.sv
module cam_cap_ctrl
  import cam_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic cfg_continuous,
  input  logic fs_evt,
  output logic capturing,
  output logic active,
  output logic frame_open
);
  cap_state_e state_q, state_d;
  logic       stop_q, stop_d;

  always_comb begin
    state_d    = state_q;
    stop_d     = stop_q;
    frame_open = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (cmd_start) state_d = ST_ARMED;
      end
      ST_ARMED, ST_CAPTURE: begin
        if (cmd_stop) stop_d = 1'b1;
        if (fs_evt) begin
          if (stop_q || cmd_stop || (state_q == ST_CAPTURE && !cfg_continuous)) begin
            state_d = ST_IDLE;
            stop_d  = 1'b0;
          end else begin
            state_d    = ST_CAPTURE;
            frame_open = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end

  assign capturing = (state_q == ST_CAPTURE);
  assign active    = (state_q != ST_IDLE);

endmodule

// File: rtl/cam_out_stage.sv
module cam_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_evt,
  input  logic              keep,
  input  logic [DATA_W-1:0] px_data,
  input  logic              frame_open,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol
);
  logic              pend_vld_q, pend_vld_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;
  logic              pend_sof_q, pend_sof_d;
  logic              sof_arm_q, sof_arm_d;
  logic              ov_q, ov_d, os_q, os_d, oe_q, oe_d;
  logic [DATA_W-1:0] od_q, od_d;
  logic              push;

  always_comb begin
    pend_vld_d  = pend_vld_q;
    pend_data_d = pend_data_q;
    pend_sof_d  = pend_sof_q;
    sof_arm_d   = sof_arm_q;
    push        = 1'b0;
    if (px_evt) begin
      // The held pixel is final in its row when the new sample is not kept.
      push       = pend_vld_q;
      pend_vld_d = keep;
      if (keep) begin
        pend_data_d = px_data;
        pend_sof_d  = sof_arm_q;
        sof_arm_d   = 1'b0;
      end
    end
    if (frame_open) sof_arm_d = 1'b1;

    ov_d = ov_q;
    od_d = od_q;
    os_d = os_q;
    oe_d = oe_q;
    if (ov_q && out_ready) ov_d = 1'b0;
    if (push && (!ov_q || out_ready)) begin
      ov_d = 1'b1;
      od_d = pend_data_q;
      os_d = pend_sof_q;
      oe_d = ~keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_sof_q  <= 1'b0;
      sof_arm_q   <= 1'b0;
      ov_q        <= 1'b0;
      od_q        <= '0;
      os_q        <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      pend_vld_q  <= pend_vld_d;
      pend_data_q <= pend_data_d;
      pend_sof_q  <= pend_sof_d;
      sof_arm_q   <= sof_arm_d;
      ov_q        <= ov_d;
      od_q        <= od_d;
      os_q        <= os_d;
      oe_q        <= oe_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sof   = os_q;
  assign out_eol   = oe_q;

endmodule

// File: rtl/cam_capture_fe.sv
module cam_capture_fe
  import cam_cap_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_pclk,
  input  logic              cam_hsync,
  input  logic              cam_vsync,
  input  logic [DATA_W-1:0] cam_data,
  input  logic              cfg_pclk_fall,
  input  logic              cfg_hsync_low,
  input  logic              cfg_vsync_low,
  input  logic [1:0]        cfg_sample_bits,
  input  logic              cfg_col_crop_en,
  input  logic              cfg_row_crop_en,
  input  logic [CNT_W-1:0]  cfg_col_first,
  input  logic [CNT_W-1:0]  cfg_col_last,
  input  logic [CNT_W-1:0]  cfg_row_first,
  input  logic [CNT_W-1:0]  cfg_row_last,
  input  logic              cfg_continuous,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol,
  output logic              status_active
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sn;
  logic              px_evt, hs_act, vs_act;
  logic [DATA_W-1:0] px_raw, px_masked;
  logic [15:0]       mask16;
  logic              fs_evt, win_hit, capturing, frame_open, keep;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  cam_in_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_sn),
    .pclk_i(cam_pclk), .hs_i(cam_hsync), .vs_i(cam_vsync), .data_i(cam_data),
    .cfg_pclk_fall(cfg_pclk_fall), .cfg_hs_low(cfg_hsync_low), .cfg_vs_low(cfg_vsync_low),
    .px_evt(px_evt), .hs_act(hs_act), .vs_act(vs_act), .px_data(px_raw)
  );

  cam_sync_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_sn),
    .px_evt(px_evt), .hs_act(hs_act), .vs_act(vs_act),
    .cfg_col_en(cfg_col_crop_en), .cfg_row_en(cfg_row_crop_en),
    .cfg_col_first(cfg_col_first), .cfg_col_last(cfg_col_last),
    .cfg_row_first(cfg_row_first), .cfg_row_last(cfg_row_last),
    .fs_evt(fs_evt), .win_hit(win_hit)
  );

  cam_cap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cfg_continuous(cfg_continuous),
    .fs_evt(fs_evt), .capturing(capturing), .active(status_active),
    .frame_open(frame_open)
  );

  always_comb begin
    mask16    = width_mask(cfg_sample_bits);
    px_masked = px_raw & mask16[DATA_W-1:0];
    keep      = px_evt & win_hit & capturing & ~fs_evt;
  end

  cam_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_sn),
    .px_evt(px_evt), .keep(keep), .px_data(px_masked), .frame_open(frame_open),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

endmodule

// File: rtl/cam_capture_fe_chk.sv
module cam_capture_fe_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sof,
  input logic              out_eol,
  input logic [1:0]        cfg_sample_bits,
  input logic              cmd_start,
  input logic              status_active,
  input logic              fs_evt,
  input logic              frame_open
);
  int unsigned width_bits;
  always_comb begin
    case (cfg_sample_bits)
      2'd0:    width_bits = 8;
      2'd1:    width_bits = 9;
      2'd2:    width_bits = 10;
      default: width_bits = 12;
    endcase
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)); // R11

  AST_NO_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> ((32'(out_data) >> width_bits) == 32'd0)); // R7

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_start && !status_active |=> status_active); // R8

  AST_END_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    status_active && !fs_evt |=> status_active); // R10

  AST_OPEN_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_open |-> fs_evt && status_active); // R9

endmodule

bind cam_capture_fe cam_capture_fe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
  .cfg_sample_bits(cfg_sample_bits), .cmd_start(cmd_start),
  .status_active(status_active), .fs_evt(fs_evt), .frame_open(frame_open)
);

// File: tb/cam_capture_fe_tb.sv
module cam_capture_fe_tb;
  localparam int DW = 12;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cam_pclk, cam_hsync, cam_vsync;
  logic [DW-1:0] cam_data;
  logic          cfg_pclk_fall, cfg_hsync_low, cfg_vsync_low;
  logic [1:0]    cfg_sample_bits;
  logic          cfg_col_crop_en, cfg_row_crop_en;
  logic [CW-1:0] cfg_col_first, cfg_col_last, cfg_row_first, cfg_row_last;
  logic          cfg_continuous, cmd_start, cmd_stop;
  logic          out_valid, out_ready, out_sof, out_eol, status_active;
  logic [DW-1:0] out_data;

  cam_capture_fe #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_hsync(cam_hsync),
    .cam_vsync(cam_vsync), .cam_data(cam_data), .cfg_pclk_fall(cfg_pclk_fall),
    .cfg_hsync_low(cfg_hsync_low), .cfg_vsync_low(cfg_vsync_low),
    .cfg_sample_bits(cfg_sample_bits), .cfg_col_crop_en(cfg_col_crop_en),
    .cfg_row_crop_en(cfg_row_crop_en), .cfg_col_first(cfg_col_first),
    .cfg_col_last(cfg_col_last), .cfg_row_first(cfg_row_first),
    .cfg_row_last(cfg_row_last), .cfg_continuous(cfg_continuous),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .status_active(status_active)
  );

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit stall_en = 1'b0;

  logic [DW-1:0] got_d[$], exp_d[$];
  bit            got_s[$], got_e[$], exp_s[$], exp_e[$];

  // Sink: decides ready for the coming edge and records handshakes.
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_en ? ((cyc % 5) >= 2) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      got_d.push_back(out_data);
      got_s.push_back(out_sof);
      got_e.push_back(out_eol);
    end
  end

  function automatic logic [DW-1:0] pattern(int r, int c);
    return DW'((r * 37 + c * 11 + 'hA5A) & 'hFFF);
  endfunction

  function automatic logic [DW-1:0] bits_mask(logic [1:0] code);
    case (code)
      2'd0:    return DW'('h0FF);
      2'd1:    return DW'('h1FF);
      2'd2:    return DW'('h3FF);
      default: return DW'('hFFF);
    endcase
  endfunction

  task automatic pix(input bit hs, input bit vs, input logic [DW-1:0] d);
    @(negedge clk);
    cam_pclk  = cfg_pclk_fall;
    cam_hsync = hs ^ cfg_hsync_low;
    cam_vsync = vs ^ cfg_vsync_low;
    cam_data  = d;
    repeat (2) @(negedge clk);
    cam_pclk = ~cfg_pclk_fall;
    @(negedge clk);
  endtask

  task automatic vs_part();
    pix(1'b0, 1'b1, '0);
    pix(1'b0, 1'b1, '0);
    pix(1'b0, 1'b0, '0);
  endtask

  task automatic lines(input int w, input int h);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) pix(1'b1, 1'b0, pattern(r, c));
      pix(1'b0, 1'b0, '0);
      pix(1'b0, 1'b0, '0);
    end
  endtask

  task automatic frame(input int w, input int h);
    vs_part();
    lines(w, h);
  endtask

  task automatic clear_q();
    got_d.delete(); got_s.delete(); got_e.delete();
    exp_d.delete(); exp_s.delete(); exp_e.delete();
  endtask

  // Expected stream for a w x h frame under the current configuration.
  task automatic build_exp(input int w, input int h);
    bit first = 1'b1;
    exp_d.delete(); exp_s.delete(); exp_e.delete();
    for (int r = 0; r < h; r++) begin
      bit any = 1'b0;
      for (int c = 0; c < w; c++) begin
        bit cin = !cfg_col_crop_en || (c >= int'(cfg_col_first) && c <= int'(cfg_col_last));
        bit rin = !cfg_row_crop_en || (r >= int'(cfg_row_first) && r <= int'(cfg_row_last));
        if (cin && rin) begin
          exp_d.push_back(pattern(r, c) & bits_mask(cfg_sample_bits));
          exp_s.push_back(first);
          exp_e.push_back(1'b0);
          first = 1'b0;
          any = 1'b1;
        end
      end
      if (any) exp_e[exp_e.size()-1] = 1'b1;
    end
  endtask

  task automatic check_stream(input string tag);
    int bad = -1;
    n_checks++;
    if (got_d.size() != exp_d.size()) bad = 0;
    else
      for (int i = 0; i < exp_d.size(); i++)
        if (bad < 0 && (got_d[i] !== exp_d[i] || got_s[i] !== exp_s[i] || got_e[i] !== exp_e[i]))
          bad = i;
    if (bad >= 0) begin
      n_err++;
      if (got_d.size() != exp_d.size())
        $display("FAIL %s: words actual=%0d expected=%0d", tag, got_d.size(), exp_d.size());
      else
        $display("FAIL %s: word %0d actual=%h sof=%0b eol=%0b expected=%h sof=%0b eol=%0b",
                 tag, bad, got_d[bad], got_s[bad], got_e[bad], exp_d[bad], exp_s[bad], exp_e[bad]);
    end
    got_d.delete(); got_s.delete(); got_e.delete();
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) cmd_start = 1'b1; else cmd_stop = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_stop  = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cam_pclk = 1'b0; cam_hsync = 1'b0; cam_vsync = 1'b0; cam_data = '0;
    cfg_pclk_fall = 1'b0; cfg_hsync_low = 1'b0; cfg_vsync_low = 1'b0;
    cfg_sample_bits = 2'd3; cfg_col_crop_en = 1'b0; cfg_row_crop_en = 1'b0;
    cfg_col_first = '0; cfg_col_last = '0; cfg_row_first = '0; cfg_row_last = '0;
    cfg_continuous = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R12 out_valid after reset", out_valid, 1'b0);
    check_bit("R12 status after reset", status_active, 1'b0);
    repeat (3) pix(1'b0, 1'b0, '0);

    // R8 R9 R3: single shot, full frame, then the next frame is ignored
    pulse(1'b1);
    check_bit("R8 status after start", status_active, 1'b1);
    lines(3, 1);                       // before any frame start: not delivered
    frame(5, 3);
    build_exp(5, 3);
    check_stream("R9 R3 R6 single-shot frame");
    check_bit("R9 status held until next frame start", status_active, 1'b1);
    vs_part();
    check_bit("R9 status after next frame start", status_active, 1'b0);
    lines(5, 3);
    exp_d.delete(); exp_s.delete(); exp_e.delete();
    check_stream("R9 second frame not captured");

    // R4 R5: sweep every inclusive window of a 6x4 frame, continuous mode
    cfg_continuous = 1'b1;
    cfg_col_crop_en = 1'b1;
    cfg_row_crop_en = 1'b1;
    pulse(1'b1);
    for (int cmin = 0; cmin < 6; cmin++)
      for (int cmax = cmin; cmax < 6; cmax++)
        for (int rmin = 0; rmin < 4; rmin++)
          for (int rmax = rmin; rmax < 4; rmax++) begin
            cfg_col_first = CW'(cmin); cfg_col_last = CW'(cmax);
            cfg_row_first = CW'(rmin); cfg_row_last = CW'(rmax);
            clear_q();
            frame(6, 4);
            build_exp(6, 4);
            check_stream("R4 R5 R6 crop window sweep");
          end

    // R4: disabled column crop passes every column despite narrow bounds
    cfg_col_first = 2; cfg_col_last = 2; cfg_row_first = 1; cfg_row_last = 2;
    cfg_col_crop_en = 1'b0;
    clear_q(); frame(6, 4); build_exp(6, 4);
    check_stream("R4 column crop disabled");
    // R5: disabled row crop passes every row
    cfg_col_crop_en = 1'b1; cfg_row_crop_en = 1'b0;
    clear_q(); frame(6, 4); build_exp(6, 4);
    check_stream("R5 row crop disabled");
    // R4: first > last keeps nothing
    cfg_col_first = 4; cfg_col_last = 1;
    clear_q(); frame(6, 4); build_exp(6, 4);
    check_stream("R4 inverted window empty");

    // R10: stop after a frame has started
    cfg_col_crop_en = 1'b0;
    clear_q();
    vs_part();
    pulse(1'b0);
    lines(6, 4);
    build_exp(6, 4);
    check_stream("R10 frame in progress completes after stop");
    check_bit("R10 status held after stop", status_active, 1'b1);
    vs_part();
    check_bit("R10 status after next frame start", status_active, 1'b0);
    lines(6, 4);
    exp_d.delete(); exp_s.delete(); exp_e.delete();
    check_stream("R10 no frame after stop");

    // R1 R2: every combination of pixel clock edge and sync levels
    cfg_continuous = 1'b0;
    for (int p = 0; p < 8; p++) begin
      cfg_pclk_fall = p[0]; cfg_hsync_low = p[1]; cfg_vsync_low = p[2];
      repeat (3) pix(1'b0, 1'b0, '0);
      clear_q();
      pulse(1'b1);
      frame(4, 3);
      build_exp(4, 3);
      check_stream("R1 R2 polarity combination");
      vs_part();
    end

    // R7: each sample width code
    cfg_pclk_fall = 1'b0; cfg_hsync_low = 1'b0; cfg_vsync_low = 1'b0;
    repeat (3) pix(1'b0, 1'b0, '0);
    for (int b = 0; b < 4; b++) begin
      cfg_sample_bits = 2'(b);
      clear_q();
      pulse(1'b1);
      frame(4, 2);
      build_exp(4, 2);
      check_stream("R7 sample width masking");
      vs_part();
    end

    // R11 R6: sink stalls up to two cycles, crop 1..4 on columns
    cfg_sample_bits = 2'd3;
    cfg_col_crop_en = 1'b1; cfg_col_first = 1; cfg_col_last = 4;
    stall_en = 1'b1;
    clear_q();
    pulse(1'b1);
    frame(6, 3);
    build_exp(6, 3);
    check_stream("R11 R6 stream under backpressure");
    vs_part();
    stall_en = 1'b0;
    check_bit("R9 idle after stalled frame", status_active, 1'b0);

    finish_run();
  end

endmodule